// File: doc/BRIEF.md
# Shadow-Latched Millisecond Real-Time Counter

This block is a free-running time-of-day counter that advances on a 1 kHz strobe. It holds a millisecond count and a seconds count. Both are visible through a small read-only word port, together with a third register: a shadow copy of the seconds count. The counter never stops. Nothing in the block pauses it, so it keeps time while the rest of the system sleeps.

Software builds a timestamp from two reads. A read of the millisecond register returns the millisecond count. In the same cycle it copies the seconds count into the shadow register. Software then reads the shadow register and forms `shadow * 1000 + milliseconds`. This is a 32-bit wrapping value. Because the copy happens in the cycle the millisecond value is taken, a rollover between the two reads cannot tear the timestamp.

The read port uses a two-state machine. RP_IDLE drives zero on the data output. RP_RESP drives the word captured from the previous request. The transition IDLE->RESP and the transition RESP->RESP are both taken on any cycle with `rd_en` high. The transition RESP->IDLE and the transition IDLE->IDLE are both taken on any cycle with `rd_en` low.

Top module: `rtc_shadow_top`

## Requirements
- R1: Reset (`rst_n` low) clears the millisecond count, the seconds count and the shadow seconds to zero, and `rd_data` reads zero.
- R2: Each clock cycle with `ms_tick` high adds one to the millisecond count. A cycle with `ms_tick` low leaves both counts unchanged.
- R3: On a tick while the millisecond count is 999, the millisecond count returns to 0 and the seconds count increases by one, both in that same cycle.
- R4: A read at byte offset 0x10 returns the millisecond count, zero-extended to 32 bits, as it stood in the request cycle. In that same cycle the shadow register loads the seconds count as it stood in the request cycle. This holds even when a tick arrives in that cycle.
- R5: The shadow register changes only on a read at offset 0x10. Ticks, rollovers, and reads at other offsets leave it unchanged.
- R6: A read at offset 0x08 returns the live seconds count. A read at offset 0x0C returns the shadow seconds.
- R7: `rd_data` carries the requested word in the cycle after `rd_en` is high, and it is zero in every cycle that does not follow a read request.
- R8: A read at any offset other than 0x08, 0x0C or 0x10 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle 1 kHz advance strobe |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read word, one cycle after the request |

## Verification
The hardest situation to reach is a millisecond read in the exact cycle of a seconds rollover. In that cycle the returned milliseconds and the latched seconds must both come from the pre-tick state. The bench first advances the count to 999 with a held tick strobe. It then raises `ms_tick` and `rd_en` (at offset 0x10) on the same falling edge. After that it checks that the read returned 999, that the shadow holds the old second, and that the live registers show the rollover.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
    localparam int RTC_ADDR_W   = 8;
    localparam int RTC_DATA_W   = 32;
    // Byte offsets decoded by software
    localparam logic [RTC_ADDR_W-1:0] OFS_SEC_LIVE   = 8'h08;
    localparam logic [RTC_ADDR_W-1:0] OFS_SEC_SHADOW = 8'h0C;
    localparam logic [RTC_ADDR_W-1:0] OFS_MSEC       = 8'h10;

    typedef enum logic [0:0] {
        RP_IDLE = 1'b0,
        RP_RESP = 1'b1
    } rp_state_t;
endpackage

// File: rtl/rtc_ms_counter.sv
module rtc_ms_counter #(
    parameter int TICKS_PER_SEC = 1000,
    localparam int MS_W = $clog2(TICKS_PER_SEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [MS_W-1:0] ms_q,
    output logic            carry
);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(TICKS_PER_SEC - 1);

    assign carry = tick && (ms_q == MS_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)      ms_q <= '0;
        else if (carry)  ms_q <= '0;
        else if (tick)   ms_q <= ms_q + MS_W'(1);
    end

    AST_MS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q <= MS_LAST); // R3
    AST_MS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ms_q)); // R2
    AST_MS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ms_q == MS_LAST) |=> ms_q == '0); // R3
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carry,
    input  logic             snap,
    output logic [SEC_W-1:0] sec_q,
    output logic [SEC_W-1:0] shadow_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q    <= '0;
            shadow_q <= '0;
        end else begin
            if (carry) sec_q    <= sec_q + SEC_W'(1);
            if (snap)  shadow_q <= sec_q;
        end
    end

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> sec_q == $past(sec_q) + SEC_W'(1)); // R3
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !carry |=> $stable(sec_q)); // R2
    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> shadow_q == $past(sec_q)); // R4
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(shadow_q)); // R5
endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
    import rtc_shadow_pkg::*;
#(
    parameter int MS_W   = 10,
    parameter int SEC_W  = 32,
    parameter int ADDR_W = RTC_ADDR_W,
    parameter int DATA_W = RTC_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [MS_W-1:0]   ms_val,
    input  logic [SEC_W-1:0]  sec_val,
    input  logic [SEC_W-1:0]  shadow_val,
    output logic              snap,
    output logic [DATA_W-1:0] rd_data
);
    rp_state_t         state_q, state_d;
    logic [DATA_W-1:0] word_d, word_q;

    assign snap = rd_en && (rd_addr == ADDR_W'(OFS_MSEC));

    always_comb begin
        word_d = '0;
        if (rd_addr == ADDR_W'(OFS_SEC_LIVE))        word_d = DATA_W'(sec_val);
        else if (rd_addr == ADDR_W'(OFS_SEC_SHADOW)) word_d = DATA_W'(shadow_val);
        else if (rd_addr == ADDR_W'(OFS_MSEC))       word_d = DATA_W'(ms_val);
    end

    always_comb begin
        unique case (state_q)
            RP_IDLE: state_d = rd_en ? RP_RESP : RP_IDLE;
            RP_RESP: state_d = rd_en ? RP_RESP : RP_IDLE;
            default: state_d = RP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) word_q <= word_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            RP_IDLE: rd_data = '0;
            RP_RESP: rd_data = word_q;
            default: rd_data = '0;
        endcase
    end

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0); // R7
    AST_RD_MS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> rd_data == DATA_W'($past(ms_val))); // R4
endmodule

// File: rtl/rtc_shadow_top.sv
module rtc_shadow_top #(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SEC_W         = 32,
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int MS_W = $clog2(TICKS_PER_SEC);

    logic [MS_W-1:0]  ms_q;
    logic [SEC_W-1:0] sec_q, shadow_q;
    logic             carry, snap;

    rtc_ms_counter #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ms (
        .clk(clk), .rst_n(rst_n), .tick(ms_tick), .ms_q(ms_q), .carry(carry)
    );

    rtc_sec_counter #(.SEC_W(SEC_W)) u_sec (
        .clk(clk), .rst_n(rst_n), .carry(carry), .snap(snap),
        .sec_q(sec_q), .shadow_q(shadow_q)
    );

    rtc_read_port #(.MS_W(MS_W), .SEC_W(SEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .ms_val(ms_q), .sec_val(sec_q), .shadow_val(shadow_q),
        .snap(snap), .rd_data(rd_data)
    );

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0); // R1
endmodule

// File: tb/rtc_shadow_top_bench.sv
module rtc_shadow_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk; // 250 MHz

    rtc_shadow_top u_rtc_shadow_top (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input bit with_tick, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; ms_tick = with_tick;
        @(negedge clk);
        rd_en = 1'b0; ms_tick = 1'b0;
        v = rd_data;
    endtask

    task automatic tick_n(input int n);
        @(negedge clk);
        ms_tick = 1'b1;
        repeat (n) @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R1 rd_data after reset", rd_data, 0);
        rd(8'h08, 0, v); check("R1 seconds", v, 0);
        rd(8'h0C, 0, v); check("R1 shadow", v, 0);
        rd(8'h10, 0, v); check("R1 msec", v, 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        tick_n(5);
        repeat (3) @(negedge clk); // idle gap, no tick
        rd(8'h10, 0, v); check("R2 msec after 5 ticks", v, 5);
        @(negedge clk); check("R7 idle cycle reads zero", rd_data, 0);
        tick_n(994);
        rd(8'h08, 0, v); check("R6 live seconds before wrap", v, 0);
        rd(8'h10, 0, v); check("R2 msec at 999", v, 999);
    endtask

    task automatic t_rollover();
        logic [31:0] v;
        tick_n(1);
        rd(8'h0C, 0, v); check("R5 shadow unchanged by rollover", v, 0);
        rd(8'h08, 0, v); check("R3 seconds after wrap", v, 1);
        rd(8'h0C, 0, v); check("R5 shadow unchanged by seconds read", v, 0);
        rd(8'h10, 0, v); check("R3 msec after wrap", v, 0);
        rd(8'h0C, 0, v); check("R4 shadow loaded by msec read", v, 1);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        tick_n(999);
        rd(8'h00, 0, v); check("R8 offset 0x00", v, 0);
        rd(8'h04, 0, v); check("R8 offset 0x04", v, 0);
        rd(8'h14, 0, v); check("R8 offset 0x14", v, 0);
        rd(8'hFC, 0, v); check("R8 offset 0xFC", v, 0);
        rd(8'h11, 0, v); check("R8 offset 0x11", v, 0);
        rd(8'h0C, 0, v); check("R5 shadow after unmapped reads", v, 1);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        rd(8'h10, 1, v); check("R4 msec read during rollover tick", v, 999);
        rd(8'h0C, 0, v); check("R4 shadow holds pre-tick seconds", v, 1);
        rd(8'h08, 0, v); check("R3 live seconds after same-cycle wrap", v, 2);
        rd(8'h10, 0, v); check("R3 msec after same-cycle wrap", v, 0);
        rd(8'h0C, 0, v); check("R4 shadow after second msec read", v, 2);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'h08;
        @(negedge clk);
        check("R7 first of back-to-back reads", rd_data, 2);
        rd_addr = 8'h14;
        @(negedge clk);
        rd_en = 1'b0;
        check("R8 unmapped in back-to-back", rd_data, 0);
        @(negedge clk);
        check("R7 zero after read burst", rd_data, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_count();
        t_rollover();
        t_unmapped();
        t_same_cycle();
        t_back_to_back();
        tick_n(37);
        t_reset();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired got=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule